// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block extends a chip's output count by driving a chain of external shift registers over three pins: a shift clock, a serial data line and a store strobe. Software writes up to 24 output values into two data registers. The block sends them to the chain as a frame, either once on a software request or again and again at one of four slow refresh rates. After the last bit, one store pulse moves all shifted values to the external latches together.

The outputs are split into two groups. The low group holds outputs 15..0 and the high group holds outputs 23..16. Each group has its own enable, and a disabled group is left out of the frame. The capture edge of the external registers can be set to rising or falling. Outputs 1 and 0 can be handed to a two-bit hardware status input, which then replaces the software values for those two lines. The block never reads anything back from the chain.

Top module: `sled_shift_out`

## Requirements
- R1: Register access uses a word index (0..4, byte offsets 0x00..0x10) and 32-bit data. A read returns the register on `bus_rdata` one cycle after the read is sampled, and `bus_rdata` keeps its value when no read is made. The fields that read back are:
  - control A (index 0): bit 31 update-pending, bit 26 edge, bits 25:24 override select.
  - control B (index 1): bits 31:30 update mode, bits 26:23 rate, bits 1:0 group enables.
  - low data (index 2): bits 15:0.
  - high data (index 3): bits 7:0.
  - spare (index 4): all 32 bits.
  
  All other bits, and all other indices, read as 0.
- R2: A frame sends the enabled outputs with the highest-numbered output first, one bit per shift-clock period. When both groups are enabled, outputs 23..16 (high data bits 7..0) are sent before outputs 15..0.
- R3: Control B bit 0 enables the low group and bit 1 enables the high group. A frame carries 16, 8, 24 or 0 bits to match. With no group enabled, a frame is only a store pulse.
- R4: Control A bit 26 selects the capture edge. When it is 0, the shift clock idles low and the data is valid at each rising edge. When it is 1, the shift clock idles high and the data is valid at each falling edge.
- R5: After the last bit, the store strobe is high for exactly one shift-clock period (2*HALF_TICKS cycles). During that time the data line is low.
- R6: Each shift-clock period is 2*HALF_TICKS core cycles, so capture edges inside a frame are exactly 2*HALF_TICKS cycles apart.
- R7: Writing control A with bit 31 = 1 starts one frame. Bit 31 reads back as 1 until that frame's store pulse ends, and then reads 0. Writing bit 31 = 0 starts nothing.
- R8: A bit-31 write made while a frame is running is held. It produces exactly one further frame after the current one, and bit 31 keeps reading 1 until that frame ends.
- R9: With control B bit 31 = 1, frames start every SLOT_TICKS*{20,10,5,4} cycles for rate codes (bits 24:23) 0..3. With bit 31 = 0, no periodic frames start and no periodic request is left pending.
- R10: A frame is never cut short. If the refresh interval is shorter than a frame, the next frame starts only after the current one has ended.
- R11: When control A bits 25:24 equal 3, outputs 1 and 0 carry `hw_status[1:0]`, sampled at frame start. For any other value of that field, they carry low data bits 1:0.
- R12: After reset, all registers read 0 and the pins are low (shift clock, data and store).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| hw_status | input | 2 | Hardware source for outputs 1:0 |
| sh_clk | output | 1 | Shift clock to the external chain |
| sh_data | output | 1 | Serial data to the external chain |
| sh_store | output | 1 | Store strobe to the external chain |

## Verification
Read data is due one cycle after the read is sampled. A frame starts on the edge after an update write lands, and a periodic frame starts one cycle after its timer expires. Every pin moves only on a clock edge. The bench drives its inputs just after the rising edge, and it decodes the pins on the falling edge, so each bit is taken from the first cycle that shows the capture edge. The store width, the spacing of capture edges and the spacing of store rises are all measured in whole cycles and compared with 2*HALF_TICKS and SLOT_TICKS multiples. Register readback after a frame is checked only once the store strobe has gone low.

// File: rtl/sled_pkg.sv
package sled_pkg;
    localparam int LO_W  = 16;
    localparam int HI_W  = 8;
    localparam int OUT_W = LO_W + HI_W;

    localparam logic [2:0] IDX_CTRL_A = 3'd0;
    localparam logic [2:0] IDX_CTRL_B = 3'd1;
    localparam logic [2:0] IDX_DATA_L = 3'd2;
    localparam logic [2:0] IDX_DATA_H = 3'd3;
    localparam logic [2:0] IDX_SPARE  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_STORE = 2'd2
    } eng_state_e;

    typedef struct packed {
        logic            edge_fall;
        logic [1:0]      hw_sel;
        logic [1:0]      upd_mode;
        logic [3:0]      rate;
        logic [1:0]      grp_en;
        logic [LO_W-1:0] data_lo;
        logic [HI_W-1:0] data_hi;
    } cfg_t;
endpackage

// File: rtl/sled_regs.sv
module sled_regs
    import sled_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic        frame_start,
    input  logic        frame_done,
    input  logic        busy,
    output logic [31:0] bus_rdata,
    output cfg_t        cfg,
    output logic        sw_req,
    output logic        sw_rb
);
    typedef struct packed {
        cfg_t        cfg;
        logic [31:0] spare;
        logic        upd_now;
        logic        upd_next;
        logic [31:0] rdata;
    } regs_t;

    regs_t q, d;
    logic  wr, rd, sw_wr;
    logic [31:0] rd_word;

    always_comb begin
        case (bus_addr)
            IDX_CTRL_A: rd_word = {q.upd_now | q.upd_next, 4'b0, q.cfg.edge_fall,
                                   q.cfg.hw_sel, 24'b0};
            IDX_CTRL_B: rd_word = {q.cfg.upd_mode, 3'b0, q.cfg.rate, 21'b0, q.cfg.grp_en};
            IDX_DATA_L: rd_word = {{(32-LO_W){1'b0}}, q.cfg.data_lo};
            IDX_DATA_H: rd_word = {{(32-HI_W){1'b0}}, q.cfg.data_hi};
            IDX_SPARE:  rd_word = q.spare;
            default:    rd_word = 32'b0;
        endcase
    end

    always_comb begin
        d     = q;
        wr    = bus_en & bus_wr;
        rd    = bus_en & ~bus_wr;
        sw_wr = wr && (bus_addr == IDX_CTRL_A) && bus_wdata[31];

        if (wr) begin
            case (bus_addr)
                IDX_CTRL_A: begin
                    d.cfg.edge_fall = bus_wdata[26];
                    d.cfg.hw_sel    = bus_wdata[25:24];
                end
                IDX_CTRL_B: begin
                    d.cfg.upd_mode = bus_wdata[31:30];
                    d.cfg.rate     = bus_wdata[26:23];
                    d.cfg.grp_en   = bus_wdata[1:0];
                end
                IDX_DATA_L: d.cfg.data_lo = bus_wdata[LO_W-1:0];
                IDX_DATA_H: d.cfg.data_hi = bus_wdata[HI_W-1:0];
                IDX_SPARE:  d.spare       = bus_wdata;
                default: ;
            endcase
        end

        if (frame_done) begin
            d.upd_now  = q.upd_next | sw_wr;
            d.upd_next = 1'b0;
        end else if (sw_wr) begin
            if (busy || frame_start) d.upd_next = 1'b1;
            else                     d.upd_now  = 1'b1;
        end

        if (rd) d.rdata = rd_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign cfg       = q.cfg;
    assign sw_req    = q.upd_now;
    assign sw_rb     = q.upd_now | q.upd_next;
endmodule

// File: rtl/sled_refresh.sv
module sled_refresh #(
    parameter int SLOT_TICKS = 2500000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       auto_en,
    input  logic [1:0] rate,
    input  logic       start,
    output logic       pend
);
    localparam int CNT_W = $clog2(SLOT_TICKS * 20);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;
    } tmr_t;

    tmr_t q, d;
    logic [CNT_W-1:0] limit;
    logic tick;

    always_comb begin
        case (rate)
            2'd0:    limit = CNT_W'(SLOT_TICKS * 20 - 1);
            2'd1:    limit = CNT_W'(SLOT_TICKS * 10 - 1);
            2'd2:    limit = CNT_W'(SLOT_TICKS * 5 - 1);
            default: limit = CNT_W'(SLOT_TICKS * 4 - 1);
        endcase
    end

    always_comb begin
        d    = q;
        tick = 1'b0;
        if (!auto_en) begin
            d = '0;
        end else begin
            if (q.cnt >= limit) begin
                d.cnt = '0;
                tick  = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
            d.pend = tick | (q.pend & ~start);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;
endmodule

// File: rtl/sled_engine.sv
module sled_engine
    import sled_pkg::*;
#(
    parameter int HALF_TICKS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  cfg_t       cfg,
    input  logic [1:0] hw_status,
    input  logic       sw_req,
    input  logic       auto_pend,
    output logic       start,
    output logic       done,
    output logic       busy,
    output logic       sh_clk,
    output logic       sh_data,
    output logic       sh_store
);
    localparam int CW     = $clog2(2 * HALF_TICKS + 1);
    localparam int LEFT_W = $clog2(OUT_W + 1);

    typedef struct packed {
        eng_state_e        st;
        logic [OUT_W-1:0]  sreg;
        logic [LEFT_W-1:0] left;
        logic [CW-1:0]     cnt;
        logic              phase;
        logic              edge_fall;
        logic              clk_o;
        logic              data_o;
        logic              store_o;
    } eng_t;

    eng_t q, d;
    logic [LO_W-1:0] lo_eff;
    logic unused_cfg;

    assign unused_cfg = ^{cfg.upd_mode, cfg.rate};

    always_comb begin
        lo_eff = cfg.data_lo;
        if (cfg.hw_sel == 2'b11) lo_eff[1:0] = hw_status;
    end

    always_comb begin
        d     = q;
        start = 1'b0;
        done  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.edge_fall = cfg.edge_fall;
                if (sw_req || auto_pend) begin
                    start   = 1'b1;
                    d.cnt   = '0;
                    d.phase = 1'b0;
                    case (cfg.grp_en)
                        2'b11: begin
                            d.sreg = {cfg.data_hi, lo_eff};
                            d.left = LEFT_W'(OUT_W);
                        end
                        2'b01: begin
                            d.sreg = {lo_eff, {HI_W{1'b0}}};
                            d.left = LEFT_W'(LO_W);
                        end
                        2'b10: begin
                            d.sreg = {cfg.data_hi, {LO_W{1'b0}}};
                            d.left = LEFT_W'(HI_W);
                        end
                        default: begin
                            d.sreg = '0;
                            d.left = '0;
                        end
                    endcase
                    d.st = (cfg.grp_en == 2'b00) ? ST_STORE : ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (q.cnt == CW'(HALF_TICKS - 1)) begin
                    d.cnt = '0;
                    if (!q.phase) begin
                        d.phase = 1'b1;
                    end else begin
                        d.phase = 1'b0;
                        d.sreg  = {q.sreg[OUT_W-2:0], 1'b0};
                        d.left  = q.left - 1'b1;
                        if (q.left == LEFT_W'(1)) d.st = ST_STORE;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_STORE: begin
                if (q.cnt == CW'(2 * HALF_TICKS - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                    done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        d.data_o  = (d.st == ST_SHIFT) & d.sreg[OUT_W-1];
        d.clk_o   = ((d.st == ST_SHIFT) & d.phase) ^ d.edge_fall;
        d.store_o = (d.st == ST_STORE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != ST_IDLE);
    assign sh_clk   = q.clk_o;
    assign sh_data  = q.data_o;
    assign sh_store = q.store_o;
endmodule

// File: rtl/sled_shift_out.sv
module sled_shift_out
    import sled_pkg::*;
#(
    parameter int HALF_TICKS = 250,
    parameter int SLOT_TICKS = 2500000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  hw_status,
    output logic        sh_clk,
    output logic        sh_data,
    output logic        sh_store
);
    cfg_t cfg;
    logic sw_req, sw_rb, auto_en, auto_pend;
    logic frame_start, frame_done, eng_busy;

    assign auto_en = cfg.upd_mode[1];

    sled_regs i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_en      (bus_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .busy        (eng_busy),
        .bus_rdata   (bus_rdata),
        .cfg         (cfg),
        .sw_req      (sw_req),
        .sw_rb       (sw_rb)
    );

    sled_refresh #(.SLOT_TICKS(SLOT_TICKS)) i_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .auto_en (auto_en),
        .rate    (cfg.rate[1:0]),
        .start   (frame_start),
        .pend    (auto_pend)
    );

    sled_engine #(.HALF_TICKS(HALF_TICKS)) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (cfg),
        .hw_status (hw_status),
        .sw_req    (sw_req),
        .auto_pend (auto_pend),
        .start     (frame_start),
        .done      (frame_done),
        .busy      (eng_busy),
        .sh_clk    (sh_clk),
        .sh_data   (sh_data),
        .sh_store  (sh_store)
    );
endmodule

// File: rtl/sled_checker.sv
module sled_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_wr,
    input logic [31:0] bus_rdata,
    input logic        sh_store,
    input logic        sh_data,
    input logic        eng_busy,
    input logic        sw_rb,
    input logic        auto_en,
    input logic        auto_pend
);
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en || bus_wr) |=> $stable(bus_rdata));

    a_r5_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> !sh_data);

    a_r5_store_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_store) |=> sh_store);

    a_r7_pend_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && sw_rb) |=> (sw_rb || $fell(eng_busy)));

    a_r9_no_auto: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !auto_pend);
endmodule

bind sled_shift_out sled_checker i_sled_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .sh_store  (sh_store),
    .sh_data   (sh_data),
    .eng_busy  (eng_busy),
    .sw_rb     (sw_rb),
    .auto_en   (auto_en),
    .auto_pend (auto_pend)
);

// File: tb/test_sled_shift_out.sv
module test_sled_shift_out;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 1;
    localparam int SLOT       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [1:0]  hw_status = 2'd0;
    logic        sh_clk, sh_data, sh_store;

    int total = 0;
    int bad   = 0;

    // pin decoder state (written only by the monitor)
    int          cyc = 0;
    logic        prev_clk = 1'b0, prev_store = 1'b0;
    logic [31:0] capt = 0;
    int          ncapt = 0, last_cap = 0, gmin = 999, gmax = 0;
    int          frames = 0, fr_bits = 0, fr_gmin = 0, fr_gmax = 0;
    logic [31:0] fr_val = 0;
    int          last_rise = 0, prev_rise = 0, sw_cnt = 0, fr_sw = 0, clr_seen = 0;
    // bench controls (written only by the main process)
    logic        tb_edge = 1'b0;
    int          clr_tog = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sled_shift_out #(.HALF_TICKS(HALF), .SLOT_TICKS(SLOT)) i_sled_shift_out (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_status(hw_status), .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (clr_seen != clr_tog) begin
            clr_seen = clr_tog;
            capt = 0; ncapt = 0; gmin = 999; gmax = 0;
        end
        if (!sh_store && (sh_clk != prev_clk) && (sh_clk == !tb_edge)) begin
            if (ncapt > 0) begin
                if (cyc - last_cap < gmin) gmin = cyc - last_cap;
                if (cyc - last_cap > gmax) gmax = cyc - last_cap;
            end
            last_cap = cyc;
            capt = {capt[30:0], sh_data};
            ncapt = ncapt + 1;
        end
        if (sh_store && !prev_store) begin
            fr_val = capt; fr_bits = ncapt; fr_gmin = gmin; fr_gmax = gmax;
            prev_rise = last_rise; last_rise = cyc;
            capt = 0; ncapt = 0; gmin = 999; gmax = 0;
            sw_cnt = 0;
            frames = frames + 1;
        end
        if (sh_store) sw_cnt = sw_cnt + 1;
        if (!sh_store && prev_store) fr_sw = sw_cnt;
        prev_clk = sh_clk;
        prev_store = sh_store;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad = bad + 1;
        $display("FAIL watchdog (all) act=150000 cycles exp=fewer");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        tick();
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        tick();
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        tick();
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        tick();
        bus_en = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wait_frames(input int target, input int limit, input string tag);
        int k = 0;
        while (frames < target && k < limit) begin
            tick();
            k++;
        end
        chk(frames >= target, tag, frames, target);
    endtask

    task automatic wait_store_low();
        int k = 0;
        while (sh_store && k < 100) begin
            tick();
            k++;
        end
        tick();
        tick();
    endtask

    task automatic do_frame(input logic e, input logic [1:0] g, input logic [15:0] lo,
                            input logic [7:0] hi, input logic [1:0] hs, input logic [1:0] hw);
        logic [31:0] v, ev, ctl;
        logic [15:0] lo_eff;
        int nb, f0;
        hw_status = hw;
        ctl = (32'(e) << 26) | (32'(hs) << 24);
        wr(3'd0, ctl);
        wr(3'd1, 32'(g));
        wr(3'd2, 32'(lo));
        wr(3'd3, 32'(hi));
        tb_edge = e;
        repeat (3) tick();
        chk(sh_clk == e, "R4 idle clock level", 32'(sh_clk), 32'(e));
        clr_tog = clr_tog + 1;
        repeat (2) tick();
        f0 = frames;
        wr(3'd0, ctl | 32'h8000_0000);
        wait_frames(f0 + 1, 300, "R7 frame after update write");
        wait_store_low();
        lo_eff = (hs == 2'b11) ? {lo[15:2], hw} : lo;
        case (g)
            2'b11:   begin ev = {8'b0, hi, lo_eff}; nb = 24; end
            2'b01:   begin ev = {16'b0, lo_eff};    nb = 16; end
            2'b10:   begin ev = {24'b0, hi};        nb = 8;  end
            default: begin ev = 0;                  nb = 0;  end
        endcase
        chk(fr_bits == nb, "R3 bit count", fr_bits, nb);
        chk(fr_val == ev, (hs == 2'b11) ? "R11 frame data" : "R2 frame data", fr_val, ev);
        chk(fr_sw == 2 * HALF, "R5 store width", fr_sw, 2 * HALF);
        if (nb >= 2)
            chk(fr_gmin == 2 * HALF && fr_gmax == 2 * HALF, "R6 bit period", fr_gmax, 2 * HALF);
        rd(3'd0, v);
        chk(v == ctl, "R7 self clear", v, ctl);
    endtask

    initial begin
        logic [31:0] v;
        int f0, f1;
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        // R12 reset state
        chk(sh_clk == 0 && sh_data == 0 && sh_store == 0, "R12 pins after reset",
            {sh_clk, sh_data, sh_store}, 0);
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk(v == 0, "R12 register reset", v, 0);
        end
        // R1 field readback
        wr(3'd0, 32'h7FFF_FFFF); rd(3'd0, v); chk(v == 32'h0700_0000, "R1 control A", v, 32'h0700_0000);
        wr(3'd1, 32'h7FFF_FFFF); rd(3'd1, v); chk(v == 32'h4780_0003, "R1 control B", v, 32'h4780_0003);
        wr(3'd2, 32'hFFFF_FFFF); rd(3'd2, v); chk(v == 32'h0000_FFFF, "R1 low data", v, 32'h0000_FFFF);
        wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, v); chk(v == 32'h0000_00FF, "R1 high data", v, 32'h0000_00FF);
        wr(3'd4, 32'hDEAD_BEEF); rd(3'd4, v); chk(v == 32'hDEAD_BEEF, "R1 spare", v, 32'hDEAD_BEEF);
        rd(3'd5, v); chk(v == 0, "R1 unmapped", v, 0);
        wr(3'd0, 0); wr(3'd1, 0);

        // sweep of edge, groups and data patterns (R2..R7)
        for (int e = 0; e < 2; e++)
            for (int g = 0; g < 4; g++)
                for (int k = 0; k < 3; k++)
                    do_frame(e[0], g[1:0], 16'(k * 16'h9E37 + 16'h1234),
                             8'(k * 8'h5B + 8'h11), 2'b00, 2'b00);

        // R11 hardware override on outputs 1:0
        do_frame(1'b0, 2'b11, 16'hFFFC, 8'hA5, 2'b11, 2'b10);
        do_frame(1'b1, 2'b01, 16'h0003, 8'h00, 2'b11, 2'b00);
        do_frame(1'b0, 2'b01, 16'h5556, 8'h00, 2'b01, 2'b01);

        // R7 write of 0 starts nothing, pending bit set during a frame
        wr(3'd1, 32'd3);
        f0 = frames;
        wr(3'd0, 32'd0);
        repeat (150) tick();
        chk(frames == f0, "R7 zero write no frame", frames, f0);
        tb_edge = 1'b0;
        clr_tog = clr_tog + 1;
        wr(3'd0, 32'h8000_0000);
        rd(3'd0, v);
        chk(v[31] == 1'b1, "R7 pending during frame", v, 32'h8000_0000);
        wait_frames(f0 + 1, 300, "R7 frame");
        wait_store_low();

        // R8 queued request
        f0 = frames;
        wr(3'd0, 32'h8000_0000);
        repeat (10) tick();
        wr(3'd0, 32'h8000_0000);
        rd(3'd0, v);
        chk(v[31] == 1'b1, "R8 queued pending", v, 32'h8000_0000);
        wait_frames(f0 + 2, 400, "R8 second frame");
        wait_store_low();
        repeat (200) tick();
        chk(frames == f0 + 2, "R8 exactly one extra frame", frames, f0 + 2);
        rd(3'd0, v);
        chk(v == 0, "R8 pending cleared", v, 0);

        // R9 periodic rates, high group only
        for (int r = 0; r < 4; r++) begin
            int slots;
            slots = (r == 0) ? 20 : (r == 1) ? 10 : (r == 2) ? 5 : 4;
            wr(3'd1, 32'h8000_0000 | (32'(r) << 23) | 32'd2);
            f0 = frames;
            wait_frames(f0 + 3, 800, "R9 periodic frames");
            chk(last_rise - prev_rise == SLOT * slots, "R9 refresh interval",
                last_rise - prev_rise, SLOT * slots);
        end
        wr(3'd1, 32'd2);
        repeat (100) tick();
        f1 = frames;
        repeat (400) tick();
        chk(frames == f1, "R9 auto off", frames, f1);

        // R10 refresh faster than frame
        wr(3'd1, 32'h8000_0000 | (32'd3 << 23) | 32'd3);
        f0 = frames;
        wait_frames(f0 + 2, 400, "R10 start");
        for (int i = 0; i < 3; i++) begin
            f1 = frames;
            wait_frames(f1 + 1, 400, "R10 next frame");
            chk(fr_bits == 24, "R10 full frame", fr_bits, 24);
            chk(last_rise - prev_rise >= 50 * HALF, "R10 no overlap",
                last_rise - prev_rise, 50 * HALF);
        end
        wr(3'd1, 32'd0);
        repeat (100) tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule